// File: doc/BRIEF.md
# Macro Result Router

This block sits behind the arithmetic stage of a small command-processing macro engine. For every instruction it takes the computed result, the destination register index and a 3-bit result code, and turns them into side effects: a register-file write, a load of the method-address register, a pop from the incoming parameter stream, and a method write on an outgoing stream. Decoding, arithmetic and branching are done elsewhere. The instruction is held until all of its side effects have completed.

A macro begins with a start pulse. The pulse clears the method-address register and the parameter bookkeeping. The first parameter that arrives is then written into register 1. Later parameters are handed out one per fetching instruction, strictly in arrival order. The method-address register holds a 12-bit method and a 6-bit step. Each method write advances the method by the step, modulo 4096, and leaves the step unchanged. A fetch after the last parameter of the macro does not stall. It supplies zero and raises a sticky underflow flag.

Top module: `macro_result_router`

## Requirements
- R1: A start pulse clears the method-address register to zero. The first parameter of the macro is then written to register 1 before any instruction is accepted.
- R2: Result codes 1, 2, 4, 6 and 7 write the instruction result to the destination register.
- R3: Result codes 0, 3 and 5 write the next parameter to the destination register. Parameters are taken in arrival order.
- R4: Result codes 2, 5, 6 and 7 load result bits 17:0 into the method-address register. A method write from the same instruction uses the loaded value.
- R5: Result codes 3, 4, 6 and 7 emit one method write. Its data is the result for codes 3 and 4, the next parameter for code 6, and result bits 17:12 zero-extended for code 7.
- R6: After each method write, the 12-bit method field (bits 11:0) advances by the 6-bit step field (bits 17:12), modulo 4096. The step field is unchanged.
- R7: A destination index of 0 produces no register write.
- R8: An instruction that needs a parameter that has not yet arrived waits for it. Meanwhile it makes no register write and accepts no new instruction.
- R9: While a method write is not accepted, its valid, method and data stay stable and no new instruction is accepted.
- R10: A fetch after the parameter marked last supplies zero without stalling and sets the underflow flag. The flag stays set until the next start pulse.
- R11: After reset, no instruction is accepted until a macro has been started, and no register write, method write or underflow is signalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new macro |
| ins_valid_i | input | 1 | Instruction presented |
| ins_ready_o | output | 1 | Instruction accepted this cycle when valid |
| ins_code_i | input | 3 | Result code |
| ins_dst_i | input | REG_IDX_W | Destination register index |
| ins_result_i | input | DATA_W | Result from the arithmetic stage |
| par_valid_i | input | 1 | Parameter word available |
| par_ready_o | output | 1 | Parameter word taken this cycle when valid |
| par_data_i | input | DATA_W | Parameter word |
| par_last_i | input | 1 | Marks the final parameter of the macro |
| rf_we_o | output | 1 | Register write strobe |
| rf_idx_o | output | REG_IDX_W | Register write index |
| rf_data_o | output | DATA_W | Register write data |
| mw_valid_o | output | 1 | Method write pending |
| mw_ready_i | input | 1 | Method write accepted |
| mw_method_o | output | METH_W | Method of the write |
| mw_data_o | output | DATA_W | Data of the write |
| underflow_o | output | 1 | Sticky parameter underflow flag |

## Verification
The bench builds the block with its default widths: 32-bit data, 3-bit register index, 12-bit method and 6-bit step. With these widths a loaded method near 4095 combined with a nonzero step reaches the modulo-4096 wrap within one or two writes. The 6-bit step also lets code 7 carry a distinct nonzero step value as its payload. The eight register indices make destination 0 easy to hit alongside ordinary writes. A short parameter window makes both the waiting fetch and the underflow fetch reachable in a few instructions.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

  typedef enum logic [2:0] {
    RC_PARM        = 3'd0,
    RC_MOVE        = 3'd1,
    RC_MOVE_LOAD   = 3'd2,
    RC_PARM_SEND   = 3'd3,
    RC_MOVE_SEND   = 3'd4,
    RC_PARM_LOAD   = 3'd5,
    RC_LOAD_PSEND  = 3'd6,
    RC_LOAD_ISEND  = 3'd7
  } rcode_e;

  typedef enum logic [1:0] {
    SD_RESULT = 2'd0,
    SD_PARAM  = 2'd1,
    SD_STEP   = 2'd2
  } sdata_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PRELOAD = 3'd1,
    ST_RUN     = 3'd2,
    ST_FETCH   = 3'd3,
    ST_SEND    = 3'd4
  } state_e;

  function automatic logic rc_fetches(rcode_e c);
    return c inside {RC_PARM, RC_PARM_SEND, RC_PARM_LOAD, RC_LOAD_PSEND};
  endfunction

  function automatic logic rc_dst_param(rcode_e c);
    return c inside {RC_PARM, RC_PARM_SEND, RC_PARM_LOAD};
  endfunction

  function automatic logic rc_loads(rcode_e c);
    return c inside {RC_MOVE_LOAD, RC_PARM_LOAD, RC_LOAD_PSEND, RC_LOAD_ISEND};
  endfunction

  function automatic logic rc_sends(rcode_e c);
    return c inside {RC_PARM_SEND, RC_MOVE_SEND, RC_LOAD_PSEND, RC_LOAD_ISEND};
  endfunction

  function automatic sdata_e rc_send_src(rcode_e c);
    case (c)
      RC_LOAD_PSEND: return SD_PARAM;
      RC_LOAD_ISEND: return SD_STEP;
      default:       return SD_RESULT;
    endcase
  endfunction

endpackage

// File: rtl/mrr_param_port.sv
module mrr_param_port #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              want_i,
  input  logic              par_valid_i,
  input  logic [DATA_W-1:0] par_data_i,
  input  logic              par_last_i,
  output logic              par_ready_o,
  output logic              got_o,
  output logic [DATA_W-1:0] data_o,
  output logic              underflow_o
);

  logic drained_q;
  logic underflow_q;

  // Once the last word is gone, requests are served with zero at once.
  assign par_ready_o = want_i && !drained_q;
  assign got_o       = want_i && (drained_q || par_valid_i);
  assign data_o      = drained_q ? '0 : par_data_i;
  assign underflow_o = underflow_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      drained_q   <= 1'b0;
      underflow_q <= 1'b0;
    end else begin
      if (par_ready_o && par_valid_i && par_last_i) drained_q <= 1'b1;
      if (want_i && drained_q) underflow_q <= 1'b1;
    end
  end

  // R10: the flag holds until the next macro start
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow_q && !clear_i |=> underflow_q);

  // R10: after the last word no further word is taken from the stream
  a_r10_no_pop_drained: assert property (@(posedge clk) disable iff (rst)
    par_ready_o && par_valid_i && par_last_i && !clear_i |=> !par_ready_o);

endmodule

// File: rtl/mrr_method_addr.sv
module mrr_method_addr #(
  parameter int METH_W = 12,
  parameter int INC_W  = 6,
  localparam int MADDR_W = METH_W + INC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear_i,
  input  logic               load_i,
  input  logic [MADDR_W-1:0] load_val_i,
  input  logic               adv_i,
  output logic [METH_W-1:0]  send_meth_o
);

  logic [MADDR_W-1:0] addr_q;
  logic [MADDR_W-1:0] view;
  logic [MADDR_W-1:0] addr_d;
  logic [METH_W-1:0]  meth;
  logic [INC_W-1:0]   step;

  // A load in the same instruction is visible to that instruction's write.
  assign view        = load_i ? load_val_i : addr_q;
  assign meth        = view[METH_W-1:0];
  assign step        = view[MADDR_W-1:METH_W];
  assign send_meth_o = meth;

  always_comb begin
    addr_d = view;
    if (adv_i) addr_d = {step, meth + METH_W'(step)};
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) addr_q <= '0;
    else                addr_q <= addr_d;
  end

  // R1: a start leaves the register at zero
  a_r1_cleared: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> addr_q == '0);

  // R6: advancing never alters the step field
  a_r6_step_kept: assert property (@(posedge clk) disable iff (rst)
    adv_i && !load_i && !clear_i |=> addr_q[MADDR_W-1:METH_W] == $past(addr_q[MADDR_W-1:METH_W]));

endmodule

// File: rtl/macro_result_router.sv
module macro_result_router #(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 3,
  parameter int METH_W    = 12,
  parameter int INC_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 ins_valid_i,
  output logic                 ins_ready_o,
  input  logic [2:0]           ins_code_i,
  input  logic [REG_IDX_W-1:0] ins_dst_i,
  input  logic [DATA_W-1:0]    ins_result_i,
  input  logic                 par_valid_i,
  output logic                 par_ready_o,
  input  logic [DATA_W-1:0]    par_data_i,
  input  logic                 par_last_i,
  output logic                 rf_we_o,
  output logic [REG_IDX_W-1:0] rf_idx_o,
  output logic [DATA_W-1:0]    rf_data_o,
  output logic                 mw_valid_o,
  input  logic                 mw_ready_i,
  output logic [METH_W-1:0]    mw_method_o,
  output logic [DATA_W-1:0]    mw_data_o,
  output logic                 underflow_o
);
  import mrr_pkg::*;

  localparam int MADDR_W = METH_W + INC_W;

  state_e               st_q;
  rcode_e               code_q;
  logic [REG_IDX_W-1:0] dst_q;
  logic [DATA_W-1:0]    res_q;

  logic                 rf_we_q;
  logic [REG_IDX_W-1:0] rf_idx_q;
  logic [DATA_W-1:0]    rf_data_q;
  logic                 mw_valid_q;
  logic [METH_W-1:0]    mw_method_q;
  logic [DATA_W-1:0]    mw_data_q;

  rcode_e               in_code;
  rcode_e               ex_code;
  logic [REG_IDX_W-1:0] ex_dst;
  logic [DATA_W-1:0]    ex_res;
  logic                 want;
  logic                 got;
  logic [DATA_W-1:0]    pval;
  logic                 accept;
  logic                 exec;
  logic                 preload_done;
  logic [METH_W-1:0]    send_meth;
  logic [DATA_W-1:0]    send_data;
  logic [DATA_W-1:0]    wr_data;

  assign in_code     = rcode_e'(ins_code_i);
  assign ins_ready_o = (st_q == ST_RUN);
  assign accept      = ins_valid_i && ins_ready_o && !start_i;
  assign want        = !start_i && ((st_q == ST_PRELOAD) || (st_q == ST_FETCH));

  // Operand source: live inputs on a direct accept, captured copy after a wait.
  assign ex_code = (st_q == ST_FETCH) ? code_q : in_code;
  assign ex_dst  = (st_q == ST_FETCH) ? dst_q  : ins_dst_i;
  assign ex_res  = (st_q == ST_FETCH) ? res_q  : ins_result_i;

  assign exec = (accept && !rc_fetches(in_code)) || ((st_q == ST_FETCH) && got);
  assign preload_done = (st_q == ST_PRELOAD) && got;

  mrr_param_port #(.DATA_W(DATA_W)) u_param (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (start_i),
    .want_i      (want),
    .par_valid_i (par_valid_i),
    .par_data_i  (par_data_i),
    .par_last_i  (par_last_i),
    .par_ready_o (par_ready_o),
    .got_o       (got),
    .data_o      (pval),
    .underflow_o (underflow_o)
  );

  mrr_method_addr #(.METH_W(METH_W), .INC_W(INC_W)) u_maddr (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (start_i),
    .load_i      (exec && rc_loads(ex_code)),
    .load_val_i  (ex_res[MADDR_W-1:0]),
    .adv_i       (exec && rc_sends(ex_code)),
    .send_meth_o (send_meth)
  );

  always_comb begin
    wr_data = rc_dst_param(ex_code) ? pval : ex_res;
    case (rc_send_src(ex_code))
      SD_PARAM: send_data = pval;
      SD_STEP:  send_data = DATA_W'(ex_res[METH_W +: INC_W]);
      default:  send_data = ex_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      code_q      <= RC_MOVE;
      dst_q       <= '0;
      res_q       <= '0;
      rf_we_q     <= 1'b0;
      rf_idx_q    <= '0;
      rf_data_q   <= '0;
      mw_valid_q  <= 1'b0;
      mw_method_q <= '0;
      mw_data_q   <= '0;
    end else begin
      rf_we_q <= 1'b0;
      if (start_i) begin
        st_q       <= ST_PRELOAD;
        mw_valid_q <= 1'b0;
      end else begin
        if (accept) begin
          code_q <= in_code;
          dst_q  <= ins_dst_i;
          res_q  <= ins_result_i;
          if (rc_fetches(in_code)) st_q <= ST_FETCH;
        end
        if (preload_done) begin
          rf_we_q   <= 1'b1;
          rf_idx_q  <= REG_IDX_W'(1);
          rf_data_q <= pval;
          st_q      <= ST_RUN;
        end
        if ((st_q == ST_SEND) && mw_ready_i) begin
          mw_valid_q <= 1'b0;
          st_q       <= ST_RUN;
        end
        if (exec) begin
          rf_we_q   <= (ex_dst != '0);
          rf_idx_q  <= ex_dst;
          rf_data_q <= wr_data;
          if (rc_sends(ex_code)) begin
            mw_valid_q  <= 1'b1;
            mw_method_q <= send_meth;
            mw_data_q   <= send_data;
            st_q        <= ST_SEND;
          end else begin
            st_q <= ST_RUN;
          end
        end
      end
    end
  end

  assign rf_we_o     = rf_we_q;
  assign rf_idx_o    = rf_idx_q;
  assign rf_data_o   = rf_data_q;
  assign mw_valid_o  = mw_valid_q;
  assign mw_method_o = mw_method_q;
  assign mw_data_o   = mw_data_q;

  // R7: register 0 is never written
  a_r7_no_reg0_write: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> rf_idx_o != '0);

  // R9: a stalled method write keeps its contents
  a_r9_send_held: assert property (@(posedge clk) disable iff (rst)
    mw_valid_o && !mw_ready_i && !start_i |=> mw_valid_o && $stable(mw_method_o) && $stable(mw_data_o));

  // R9: no instruction enters while a method write is outstanding
  a_r9_no_accept_in_send: assert property (@(posedge clk) disable iff (rst)
    mw_valid_o |-> !ins_ready_o);

  // R8: a pending fetch without data keeps the instruction stage closed
  a_r8_fetch_blocks: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FETCH) && !got && !start_i |=> !ins_ready_o && !rf_we_o);

endmodule

// File: tb/macro_result_router_test.sv
module macro_result_router_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [2:0]  ins_code = '0;
  logic [2:0]  ins_dst = '0;
  logic [31:0] ins_result = '0;
  logic        par_valid = 1'b0;
  logic        par_ready;
  logic [31:0] par_data = '0;
  logic        par_last = 1'b0;
  logic        rf_we;
  logic [2:0]  rf_idx;
  logic [31:0] rf_data;
  logic        mw_valid;
  logic        mw_ready = 1'b1;
  logic [11:0] mw_method;
  logic [31:0] mw_data;
  logic        underflow;

  always #5 clk = ~clk;

  macro_result_router uut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .ins_valid_i(ins_valid), .ins_ready_o(ins_ready), .ins_code_i(ins_code),
    .ins_dst_i(ins_dst), .ins_result_i(ins_result),
    .par_valid_i(par_valid), .par_ready_o(par_ready), .par_data_i(par_data),
    .par_last_i(par_last),
    .rf_we_o(rf_we), .rf_idx_o(rf_idx), .rf_data_o(rf_data),
    .mw_valid_o(mw_valid), .mw_ready_i(mw_ready), .mw_method_o(mw_method),
    .mw_data_o(mw_data), .underflow_o(underflow)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] prm [64];
  int pidx = 0;
  int avail = 0;
  int wend = 0;
  bit pfire = 1'b0;
  bit rdy_en = 1'b1;

  logic [34:0] act_rf [256];
  logic [34:0] exp_rf [256];
  logic [43:0] act_mw [256];
  logic [43:0] exp_mw [256];
  int n_act_rf = 0, n_exp_rf = 0, n_act_mw = 0, n_exp_mw = 0;
  int cmp_rf = 0, cmp_mw = 0;

  logic [17:0] m_maddr = '0;
  int m_pidx = 0, m_end = 0, cur = 0;

  // Stream driver and output logger, all at the falling edge.
  always @(negedge clk) begin
    if (pfire) pidx = pidx + 1;
    par_valid = (pidx < avail);
    par_data  = prm[pidx % 64];
    par_last  = (pidx == wend - 1);
    pfire     = par_valid && par_ready;
    mw_ready  = rdy_en;
    if (rf_we) begin act_rf[n_act_rf] = {rf_idx, rf_data}; n_act_rf++; end
    if (mw_valid && mw_ready) begin act_mw[n_act_mw] = {mw_method, mw_data}; n_act_mw++; end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic push_rf(input logic [2:0] idx, input logic [31:0] d);
    if (idx != 3'd0) begin exp_rf[n_exp_rf] = {idx, d}; n_exp_rf++; end
  endtask

  task automatic start_macro(input int n, input int av);
    tick();
    wend = cur + n; avail = cur + av; start_i = 1'b1;
    m_pidx = cur; m_end = cur + n; m_maddr = '0;
    push_rf(3'd1, prm[m_pidx % 64]); m_pidx++;
    cur = cur + n;
    tick();
    start_i = 1'b0;
  endtask

  function automatic logic [31:0] m_fetch();
    logic [31:0] p;
    if (m_pidx < m_end) begin p = prm[m_pidx % 64]; m_pidx++; end
    else p = '0;
    return p;
  endfunction

  // Reference behaviour of one instruction, from the requirements.
  task automatic model(input logic [2:0] c, input logic [2:0] d, input logic [31:0] r);
    logic [31:0] p;
    logic [31:0] sd;
    p = '0;
    if (c inside {3'd0, 3'd3, 3'd5, 3'd6}) p = m_fetch();
    push_rf(d, (c inside {3'd0, 3'd3, 3'd5}) ? p : r);
    if (c inside {3'd2, 3'd5, 3'd6, 3'd7}) m_maddr = r[17:0];
    if (c inside {3'd3, 3'd4, 3'd6, 3'd7}) begin
      sd = (c == 3'd6) ? p : (c == 3'd7) ? {26'd0, r[17:12]} : r;
      exp_mw[n_exp_mw] = {m_maddr[11:0], sd}; n_exp_mw++;
      m_maddr[11:0] = m_maddr[11:0] + {6'd0, m_maddr[17:12]};
    end
  endtask

  task automatic run_instr(input logic [2:0] c, input logic [2:0] d, input logic [31:0] r);
    model(c, d, r);
    tick();
    ins_valid = 1'b1; ins_code = c; ins_dst = d; ins_result = r;
    while (!ins_ready) tick();
    tick();
    ins_valid = 1'b0;
  endtask

  task automatic check_logs(input string req);
    repeat (6) tick();
    chk(n_act_rf == n_exp_rf, {req, " rf count"}, 64'(n_act_rf), 64'(n_exp_rf));
    for (int i = cmp_rf; i < n_exp_rf; i++)
      chk(act_rf[i] == exp_rf[i], {req, " rf write"}, 64'(act_rf[i]), 64'(exp_rf[i]));
    chk(n_act_mw == n_exp_mw, {req, " mw count"}, 64'(n_act_mw), 64'(n_exp_mw));
    for (int i = cmp_mw; i < n_exp_mw; i++)
      chk(act_mw[i] == exp_mw[i], {req, " method write"}, 64'(act_mw[i]), 64'(exp_mw[i]));
    cmp_rf = n_exp_rf; cmp_mw = n_exp_mw;
  endtask

  // {code, dst, result}
  localparam logic [37:0] VEC [16] = '{
    {3'd4, 3'd2, 32'h1111_0001},
    {3'd2, 3'd3, 32'h0000_3FFE},
    {3'd4, 3'd4, 32'hDEAD_BEEF},
    {3'd4, 3'd0, 32'hCAFE_0000},
    {3'd3, 3'd5, 32'h0000_00AA},
    {3'd0, 3'd6, 32'h1234_5678},
    {3'd1, 3'd7, 32'h8765_4321},
    {3'd1, 3'd0, 32'h5555_5555},
    {3'd5, 3'd2, 32'h0001_1100},
    {3'd6, 3'd3, 32'h0002_0200},
    {3'd7, 3'd4, 32'h00FC_5ABC},
    {3'd4, 3'd1, 32'h0000_0000},
    {3'd0, 3'd0, 32'h7777_7777},
    {3'd2, 3'd1, 32'h0000_0FFF},
    {3'd4, 3'd1, 32'h0000_0001},
    {3'd4, 3'd1, 32'h0000_0002}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) prm[i] = (32'h5A00_0000 ^ (i * 32'h0001_0203)) + 32'(i) + 32'd1;
    repeat (3) tick();
    rst = 1'b0;
    repeat (3) tick();
    // R11: idle after reset
    chk(ins_ready == 1'b0, "R11 ins_ready", 64'(ins_ready), 64'd0);
    chk(n_act_rf == 0 && n_act_mw == 0, "R11 no writes", 64'(n_act_rf + n_act_mw), 64'd0);
    chk(underflow == 1'b0, "R11 underflow", 64'(underflow), 64'd0);

    // Table walk: R1 R2 R3 R4 R5 R6 R7
    start_macro(6, 6);
    for (int i = 0; i < 16; i++) run_instr(VEC[i][37:35], VEC[i][34:32], VEC[i][31:0]);
    check_logs("R1 R2 R3 R4 R5 R6 R7");

    // R1: method address cleared by a new start
    start_macro(1, 1);
    run_instr(3'd4, 3'd2, 32'h0000_0007);
    check_logs("R1");

    // R8: fetch waits for a late parameter
    start_macro(2, 1);
    run_instr(3'd0, 3'd5, 32'h0);
    repeat (5) tick();
    chk(n_act_rf == n_exp_rf - 1, "R8 write held", 64'(n_act_rf), 64'(n_exp_rf - 1));
    chk(ins_ready == 1'b0, "R8 ins_ready", 64'(ins_ready), 64'd0);
    avail = wend;
    check_logs("R8");

    // R9: method write stalled by the consumer
    rdy_en = 1'b0;
    run_instr(3'd4, 3'd2, 32'h0BAD_F00D);
    repeat (5) tick();
    chk(mw_valid == 1'b1, "R9 valid held", 64'(mw_valid), 64'd1);
    chk(mw_data == 32'h0BAD_F00D, "R9 data held", 64'(mw_data), 64'h0BAD_F00D);
    chk(n_act_mw == n_exp_mw - 1, "R9 not taken", 64'(n_act_mw), 64'(n_exp_mw - 1));
    chk(ins_ready == 1'b0, "R9 ins_ready", 64'(ins_ready), 64'd0);
    rdy_en = 1'b1;
    check_logs("R9");

    // R10: fetch past the last parameter
    start_macro(1, 1);
    run_instr(3'd0, 3'd3, 32'h1357_9BDF);
    run_instr(3'd1, 3'd4, 32'h0000_0009);
    check_logs("R10");
    chk(underflow == 1'b1, "R10 flag set", 64'(underflow), 64'd1);
    start_macro(1, 1);
    chk(underflow == 1'b0, "R10 flag cleared", 64'(underflow), 64'd0);
    check_logs("R10 R1");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule